// File: doc/BRIEF.md
# ATM Cell Egress Word-to-Byte Unpacker

This block moves stored 54-byte ATM cells from a user-side cell buffer to a link-layer device over an 8-bit, UTOPIA Level 1 style receive port. It reads each cell from the buffer as 27 16-bit words and splits every word into two bytes. The upper byte goes out first. A start-of-cell flag marks the first header byte.

A mode input selects how many bytes leave per cell. With the mode high, all 54 stored bytes are sent. With the mode low, the sixth stored byte (the low half of word 2, a copy of the fifth header byte) is dropped, so 53 bytes leave. The link layer pulls bytes by holding its active-low enable low. While the enable is high, the port holds its current byte. A small word queue lets the buffer be read ahead, so no idle cycles appear inside a cell.

Top module: `cell_egress_unpacker`

## Requirements
- R1: While `rst_n` is low at a rising clock edge (synchronous reset), the following hold after that edge for as long as reset is held: `link_clav`, `link_soc` and `buf_rd_en` are 0, `buf_rd_addr` is 0x00 and `link_data` is 0x00.
- R2: With no cell in progress and `usr_ready` low, the block issues no buffer reads and `link_clav` stays 0.
- R3: `usr_ready` high with no cell in progress starts a cell. `link_clav` goes to 1 once the first word has arrived. The cell is committed, so it is delivered in full even if `usr_ready` then falls.
- R4: Each cell is read as exactly 27 words with `buf_rd_en` active high. The addresses are 0x00, 0x01, … 0x1A, in order. Read data is taken on `buf_rd_data` in the cycle after the read is issued.
- R5: Each word is sent upper byte (bits 15:8) first, then lower byte (bits 7:0).
- R6: With `pass54` high, all 54 stored bytes are sent in stored order.
- R7: With `pass54` low, stored byte index 5 (bits 7:0 of word 2) is skipped, and 53 bytes are sent.
- R8: `pass54` is sampled when a cell starts. Changing it during the cell has no effect on that cell.
- R9: `link_soc` is 1 only while the first byte of a cell (stored byte 0) is presented.
- R10: A byte is transferred on each rising edge where `link_en_n` is low and `link_clav` is high. While `link_en_n` is high, `link_data` and `link_soc` hold, and transfer resumes from the same byte.
- R11: After the last byte of a cell, `buf_rd_addr` is back at 0x00 and `link_clav` falls. A new cell starts only if `usr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-side clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pass54 | input | 1 | 1: send 54 bytes; 0: drop stored byte 5 and send 53 |
| usr_ready | input | 1 | User has a complete cell ready to send |
| buf_rd_en | output | 1 | Buffer read enable, active high |
| buf_rd_addr | output | 5 | Buffer word address, 0x00–0x1A |
| buf_rd_data | input | 16 | Buffer word, valid the cycle after the read |
| link_en_n | input | 1 | Link-layer enable, active low; low pulls one byte |
| link_clav | output | 1 | Cell byte available to the link layer |
| link_soc | output | 1 | Start-of-cell marker on the first byte |
| link_data | output | 8 | Byte presented to the link layer |

## Verification
Cells with random word contents are sent in both byte-count modes. In each cell the enable is either held low throughout or paused at random. Continuous pulling exposes read-ahead gaps and wrong byte order. Random pauses show whether bytes advance only on enabled cycles and hold steady otherwise. Directed cases cover:
- switching the mode mid-cell, which separates a latched mode from a live one;
- back-to-back cells with the ready input held high, which test the return of the address and the start-of-cell flag;
- reset in the middle of a cell;
- a long quiet stretch with ready low.

// File: rtl/egress_unpack_pkg.sv
// Shared constants for the cell egress unpacker.
// Assumes a 54-byte stored cell held as 16-bit words.
package egress_unpack_pkg;
    localparam int EU_WORD_W     = 16;  // buffer word width
    localparam int EU_ADDR_W     = 5;   // buffer word address width
    localparam int EU_CELL_WORDS = 27;  // words per stored cell
    localparam int EU_SKIP_POS   = 5;   // stored byte dropped in short mode
    localparam int EU_FIFO_DEPTH = 2;   // read-ahead words
endpackage

// File: rtl/eu_word_fifo.sv
// Small word queue between buffer reads and the byte splitter.
// Assumes the caller never pushes when full nor pops when empty.
module eu_word_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic                         valid,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slot_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;

    // Storage, pointers and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                slot_q[wr_q] <= din;
                wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            end
            if (pop) begin
                rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            end
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    // Head word and status outputs.
    always_comb begin
        dout  = slot_q[rd_q];
        valid = (cnt_q != '0);
        count = cnt_q;
    end
endmodule

// File: rtl/eu_read_seq.sv
// Read sequencer: starts a cell when the user is ready and walks the
// word addresses in order. It issues a read whenever the queue plus the
// read in flight leaves room. Assumes a read returns data one cycle later.
module eu_read_seq #(
    parameter int ADDR_W     = 5,
    parameter int CELL_WORDS = 27,
    parameter int DEPTH      = 2,
    parameter int CNT_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usr_ready,
    input  logic              pass54,
    input  logic              cell_done,
    input  logic              pop,
    input  logic [CNT_W-1:0]  fifo_cnt,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_pend,
    output logic              mode54
);
    localparam int OW = CNT_W + 1;
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(CELL_WORDS - 1);

    logic              busy_q, done_q, pend_q, mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [OW-1:0]     occ;

    // Words held or in flight after this cycle's pop.
    always_comb begin
        occ   = OW'(fifo_cnt) + OW'(pend_q) - OW'(pop);
        rd_en = busy_q && !done_q && (occ < OW'(DEPTH));
    end

    // Cell start/end, address walk and read-in-flight tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            pend_q <= 1'b0;
            mode_q <= 1'b0;
            addr_q <= '0;
        end else begin
            pend_q <= rd_en;
            if (rd_en) begin
                if (addr_q == LAST) begin
                    addr_q <= '0;
                    done_q <= 1'b1;
                end else begin
                    addr_q <= addr_q + 1'b1;
                end
            end
            if (!busy_q && usr_ready) begin
                busy_q <= 1'b1;
                mode_q <= pass54;
            end else if (cell_done) begin
                busy_q <= 1'b0;
                done_q <= 1'b0;
            end
        end
    end

    assign rd_addr = addr_q;
    assign rd_pend = pend_q;
    assign mode54  = mode_q;
endmodule

// File: rtl/eu_byte_sel.sv
// Byte splitter: presents one byte of the head word at a time, upper
// half first. It advances on enabled cycles and skips the duplicate
// header byte in short mode. Assumes the head word is valid whenever
// the queue reports it so.
module eu_byte_sel #(
    parameter int BYTE_W     = 8,
    parameter int CELL_BYTES = 54,
    parameter int SKIP_POS   = 5,
    parameter int BIDX_W     = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*BYTE_W-1:0] head,
    input  logic                head_valid,
    input  logic                en_n,
    input  logic                mode54,
    output logic                pop,
    output logic                cell_done,
    output logic [BYTE_W-1:0]   data,
    output logic                soc
);
    logic [BIDX_W-1:0] bidx_q;
    logic              send, skip_next;

    // Transfer, word-consume and end-of-cell decisions.
    always_comb begin
        send      = head_valid && !en_n;
        skip_next = !mode54 && (bidx_q == BIDX_W'(SKIP_POS - 1));
        pop       = send && (bidx_q[0] || skip_next);
        cell_done = send && (bidx_q == BIDX_W'(CELL_BYTES - 1));
    end

    // Stored-byte index of the byte being presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bidx_q <= '0;
        end else if (send) begin
            if (cell_done)      bidx_q <= '0;
            else if (skip_next) bidx_q <= bidx_q + BIDX_W'(2);
            else                bidx_q <= bidx_q + BIDX_W'(1);
        end
    end

    // Byte lane select and start-of-cell marker.
    always_comb begin
        if (!head_valid)    data = '0;
        else if (bidx_q[0]) data = head[BYTE_W-1:0];
        else                data = head[2*BYTE_W-1:BYTE_W];
        soc = head_valid && (bidx_q == '0);
    end
endmodule

// File: rtl/cell_egress_unpacker.sv
// Top level: reads stored cells word by word from a user buffer and
// sends them as bytes to a link-layer receive port. Single clock domain.
// Assumes the user raises usr_ready only with a complete cell stored.
module cell_egress_unpacker
    import egress_unpack_pkg::*;
#(
    parameter int WORD_W     = EU_WORD_W,
    parameter int ADDR_W     = EU_ADDR_W,
    parameter int CELL_WORDS = EU_CELL_WORDS,
    parameter int SKIP_POS   = EU_SKIP_POS,
    parameter int FIFO_DEPTH = EU_FIFO_DEPTH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pass54,
    input  logic                usr_ready,
    output logic                buf_rd_en,
    output logic [ADDR_W-1:0]   buf_rd_addr,
    input  logic [WORD_W-1:0]   buf_rd_data,
    input  logic                link_en_n,
    output logic                link_clav,
    output logic                link_soc,
    output logic [WORD_W/2-1:0] link_data
);
    localparam int BYTE_W     = WORD_W / 2;
    localparam int CELL_BYTES = 2 * CELL_WORDS;
    localparam int BIDX_W     = $clog2(CELL_BYTES);
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);

    logic              push, pop, head_valid, cell_done, mode54;
    logic [WORD_W-1:0] head;
    logic [CNT_W-1:0]  fifo_cnt;

    eu_read_seq #(
        .ADDR_W(ADDR_W), .CELL_WORDS(CELL_WORDS),
        .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .usr_ready(usr_ready), .pass54(pass54),
        .cell_done(cell_done), .pop(pop), .fifo_cnt(fifo_cnt),
        .rd_en(buf_rd_en), .rd_addr(buf_rd_addr), .rd_pend(push),
        .mode54(mode54)
    );

    eu_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(buf_rd_data),
        .pop(pop), .dout(head), .valid(head_valid), .count(fifo_cnt)
    );

    eu_byte_sel #(
        .BYTE_W(BYTE_W), .CELL_BYTES(CELL_BYTES),
        .SKIP_POS(SKIP_POS), .BIDX_W(BIDX_W)
    ) u_sel (
        .clk(clk), .rst_n(rst_n), .head(head), .head_valid(head_valid),
        .en_n(link_en_n), .mode54(mode54), .pop(pop),
        .cell_done(cell_done), .data(link_data), .soc(link_soc)
    );

    assign link_clav = head_valid;
endmodule

// File: rtl/eu_checker.sv
// Port-level protocol checks for the cell egress unpacker.
module eu_checker #(
    parameter int ADDR_W = 5,
    parameter int BYTE_W = 8,
    parameter int CELL_WORDS = 27
) (
    input logic              clk,
    input logic              rst_n,
    input logic              usr_ready,
    input logic              link_en_n,
    input logic              link_clav,
    input logic              link_soc,
    input logic [BYTE_W-1:0] link_data,
    input logic              buf_rd_en,
    input logic [ADDR_W-1:0] buf_rd_addr
);
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |-> (buf_rd_addr <= ADDR_W'(CELL_WORDS - 1)));  // R4
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |=> (buf_rd_addr == $past(buf_rd_addr) + 1'b1 || buf_rd_addr == '0));  // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!usr_ready && !link_clav && !buf_rd_en) |=> !buf_rd_en);  // R2
    AST_HOLD_ON_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (link_clav && link_en_n) |=> ($stable(link_data) && $stable(link_soc)));  // R10
    AST_SOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (link_soc && !link_en_n) |=> !link_soc);  // R9
    AST_SOC_NEEDS_CLAV: assert property (@(posedge clk) disable iff (!rst_n)
        link_soc |-> link_clav);  // R9
endmodule

bind cell_egress_unpacker eu_checker #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .CELL_WORDS(CELL_WORDS)
) i_chk (
    .clk(clk), .rst_n(rst_n), .usr_ready(usr_ready), .link_en_n(link_en_n),
    .link_clav(link_clav), .link_soc(link_soc), .link_data(link_data),
    .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr)
);

// File: tb/test_cell_egress_unpacker.sv
module test_cell_egress_unpacker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pass54 = 1'b1;
    logic        usr_ready = 1'b0;
    logic        link_en_n = 1'b1;
    logic [15:0] buf_rd_data = '0;
    logic        buf_rd_en, link_clav, link_soc;
    logic [4:0]  buf_rd_addr;
    logic [7:0]  link_data;

    int n_run = 0;
    int n_fail = 0;
    int addr_err = 0;
    int rd_total = 0;
    int exp_addr = 0;
    logic [15:0] mem [27];

    always #4 clk = ~clk;

    cell_egress_unpacker i_cell_egress_unpacker (
        .clk(clk), .rst_n(rst_n), .pass54(pass54), .usr_ready(usr_ready),
        .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr),
        .buf_rd_data(buf_rd_data), .link_en_n(link_en_n),
        .link_clav(link_clav), .link_soc(link_soc), .link_data(link_data)
    );

    // Buffer model with one-cycle read latency and an address-order monitor.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_addr = 0;
        end else if (buf_rd_en) begin
            rd_total++;
            if (int'(buf_rd_addr) != exp_addr) addr_err++;
            exp_addr = (exp_addr == 26) ? 0 : exp_addr + 1;
            if (buf_rd_addr < 5'd27) buf_rd_data <= mem[buf_rd_addr];
            else buf_rd_data <= 16'hDEAD;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] stored_byte(input int j);
        return j[0] ? mem[j/2][7:0] : mem[j/2][15:8];
    endfunction

    function automatic int stored_index(input bit m, input int k);
        return (!m && k >= 5) ? k + 1 : k;
    endfunction

    // Sends one cell and checks its bytes; leaves the bench at the
    // negedge after the last transfer.
    task automatic run_cell(input bit m, input int pause_pct,
                            input bit flip, input bit keep_ready);
        int nbytes = m ? 54 : 53;
        int k = 0;
        int guard = 0;
        int data_err = 0;
        int soc_err = 0;
        int rd0;
        int aerr0;
        for (int i = 0; i < 27; i++) mem[i] = 16'($urandom);
        rd0 = rd_total;
        aerr0 = addr_err;
        pass54 = m;
        @(negedge clk);
        usr_ready = 1'b1;
        while (!link_clav && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        chk(link_clav == 1'b1, "R3 clav after ready", int'(link_clav), 1);
        if (!keep_ready) usr_ready = 1'b0;
        if (flip) pass54 = ~m;
        guard = 0;
        while (k < nbytes && guard < 4000) begin
            link_en_n = ($urandom_range(99) < pause_pct);
            #2;
            if (link_data != stored_byte(stored_index(m, k))) data_err++;
            if (link_soc != (k == 0)) soc_err++;
            if (!link_en_n && link_clav) k++;
            @(negedge clk);
            guard++;
        end
        link_en_n = 1'b1;
        #2;
        if (m) chk(data_err == 0, "R6 R5 R10 54-byte data", data_err, 0);
        else   chk(data_err == 0, "R7 R5 R10 53-byte data", data_err, 0);
        if (flip) chk(data_err == 0 && k == nbytes, "R8 mode latched", k, nbytes);
        chk(soc_err == 0, "R9 soc on first byte only", soc_err, 0);
        chk(link_clav == 1'b0, "R11 clav low after last byte", int'(link_clav), 0);
        chk(buf_rd_addr == 5'd0, "R11 address back to zero", int'(buf_rd_addr), 0);
        chk(rd_total - rd0 == 27, "R4 word reads per cell", rd_total - rd0, 27);
        chk(addr_err == aerr0, "R4 address order", addr_err - aerr0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 27; i++) mem[i] = '0;
        // R1: reset held with ready high
        usr_ready = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            #2;
            chk(!link_clav && !link_soc && !buf_rd_en && buf_rd_addr == 0 && link_data == 0,
                "R1 reset state", {link_clav, link_soc, buf_rd_en}, 0);
        end
        usr_ready = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        // R2: idle with ready low
        begin
            int r0 = rd_total;
            int seen = 0;
            for (int c = 0; c < 30; c++) begin
                @(negedge clk);
                #2;
                if (link_clav) seen++;
            end
            chk(seen == 0, "R2 clav stays low when idle", seen, 0);
            chk(rd_total == r0, "R2 no reads when idle", rd_total - r0, 0);
        end
        // directed: continuous pull, both modes
        run_cell(1'b1, 0, 1'b0, 1'b0);
        run_cell(1'b0, 0, 1'b0, 1'b0);
        // directed: long pauses
        run_cell(1'b0, 80, 1'b0, 1'b0);
        // R8: mode flipped mid-cell
        run_cell(1'b0, 30, 1'b1, 1'b0);
        run_cell(1'b1, 30, 1'b1, 1'b0);
        // R11: back-to-back cells with ready held high
        run_cell(1'b1, 0, 1'b0, 1'b1);
        run_cell(1'b0, 10, 1'b0, 1'b1);
        run_cell(1'b1, 20, 1'b0, 1'b0);
        // random cells
        for (int n = 0; n < 20; n++)
            run_cell(1'($urandom_range(1)), $urandom_range(60), 1'b0, 1'($urandom_range(1)));
        usr_ready = 1'b0;
        repeat (6) @(negedge clk);
        // R1: reset in the middle of a cell
        usr_ready = 1'b1;
        while (!link_clav) @(negedge clk);
        usr_ready = 1'b0;
        link_en_n = 1'b0;
        repeat (10) @(negedge clk);
        link_en_n = 1'b1;
        rst_n = 1'b0;
        usr_ready = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            #2;
            chk(!link_clav && !link_soc && !buf_rd_en && buf_rd_addr == 0,
                "R1 reset mid-cell", {link_clav, link_soc, buf_rd_en}, 0);
        end
        usr_ready = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_cell(1'b0, 25, 1'b0, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule